// File: doc/BRIEF.md
# Register-Mapped Auxiliary-Channel Request Engine

This block lets a host build one display auxiliary-channel request through an 8-bit register bus, launch it, and collect the reply. The host loads a 20-bit target address, a 4-bit command and a length code, and pushes write payload into an internal FIFO through a data port register. Setting the send bit hands the request to a link-side port. While the request is in flight the send bit reads back as set.

The link side takes the request with a valid/ready handshake. It pops write bytes, pushes reply bytes, and ends the request with a reply class and a byte count. The engine keeps the class and the count in a status byte. Reply bytes are drained in arrival order through a read-data port register. If the command is not a supported one, or the link never replies, the engine completes the request by itself.

Line coding, electrical signalling and any serial host bus are outside this block.

Top module: `aux_req_engine`

## Requirements
- R1: After reset, every readable register returns 0x00. A register read returns its data on `bus_rdata` one cycle after the `bus_rd` strobe. The register offsets are: config 0x76, address bytes 0x7D (bits 7:0), 0x7E (bits 15:8) and 0x7F, length 0x80, write port 0x81, read port 0x82, control 0x83, status 0x84.
- R2: Writing 0xFF to 0x76 empties both FIFOs, clears status to 0x00 and aborts a request in flight, so the control register reads 0 afterwards.
- R3: `lnk_addr` is the 20-bit address. Bits 19:16 come from the low nibble of 0x7F. `lnk_cmd` is the high nibble of 0x7F. `lnk_req_valid` stays high until `lnk_req_ready` is seen.
- R4: Register 0x80 holds the byte count minus one in bits 3:0 and a no-payload flag in bit 7. `lnk_len` is 0 when the flag is set, and the code plus one otherwise.
- R5: Each write to 0x81 appends a byte to the write FIFO. `lnk_wdata` shows the oldest byte, or 0x00 when the FIFO is empty. Pushes beyond 16 bytes are dropped.
- R6: Writing 1 to bit 0 of 0x83 launches the request. Bit 0 reads 1 while the request is in flight and clears by itself on completion.
- R7: On `lnk_rsp_valid`, status 0x84 becomes {class[2:0] in bits 7:5, count[4:0] in bits 4:0}, taken from the reply inputs.
- R8: Reply bytes pushed by the link are read from 0x82 in arrival order. A read of an empty FIFO returns 0x00. Pushes beyond 16 bytes are dropped.
- R9: A launch with a command other than 0x8, 0x9, 0x0 or 0x1 never raises `lnk_req_valid`, and leaves status 0x80 (class 4).
- R10: If the link gives no reply within TIMEOUT_CYCLES cycles of launch, status becomes 0xE0 (class 7) and the send bit clears.
- R11: While the send bit is set, writes to 0x7D–0x80 and 0x81 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| lnk_req_valid | output | 1 | Request offered to link |
| lnk_req_ready | input | 1 | Link accepts request |
| lnk_cmd | output | 4 | Request command |
| lnk_addr | output | 20 | Request address |
| lnk_len | output | 5 | Payload byte count (0 to 16) |
| lnk_wdata | output | 8 | Head of write FIFO |
| lnk_wpop | input | 1 | Link consumes one write byte |
| lnk_rpush | input | 1 | Link delivers one reply byte |
| lnk_rdata | input | 8 | Reply byte |
| lnk_rsp_valid | input | 1 | Reply complete |
| lnk_rsp_class | input | 3 | Reply class |
| lnk_rsp_count | input | 5 | Bytes transferred |

## Verification
A register read is due on `bus_rdata` one clock after its strobe. The link-side request outputs appear one clock after the send write. Status and the send bit change on the clock that samples `lnk_rsp_valid` or the last timeout cycle. The bench drives every input on a falling edge and samples on the next falling edge, so each check lands after exactly the register stages between stimulus and result. Request timeout is checked by polling the send bit with a bounded loop, and the final status code is then compared.

// File: rtl/auxeng_pkg.sv
package auxeng_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_t;

  localparam logic [7:0] OFS_CFG   = 8'h76;
  localparam logic [7:0] OFS_A0    = 8'h7D;
  localparam logic [7:0] OFS_A1    = 8'h7E;
  localparam logic [7:0] OFS_A2    = 8'h7F;
  localparam logic [7:0] OFS_LEN   = 8'h80;
  localparam logic [7:0] OFS_WPORT = 8'h81;
  localparam logic [7:0] OFS_RPORT = 8'h82;
  localparam logic [7:0] OFS_CTRL  = 8'h83;
  localparam logic [7:0] OFS_STAT  = 8'h84;

  localparam logic [2:0] CLS_INVALID = 3'd4;
  localparam logic [2:0] CLS_TIMEOUT = 3'd7;

  function automatic logic is_known_cmd(input logic [3:0] c);
    return (c == 4'h8) || (c == 4'h9) || (c == 4'h0) || (c == 4'h1);
  endfunction
endpackage

// File: rtl/auxeng_fifo.sv
module auxeng_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign do_push = push && (count != FULLCNT);
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    count <= FULLCNT);
  p_flush_clears_r2: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/auxeng_seq.sv
module auxeng_seq
  import auxeng_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       launch,
  input  logic [3:0] cmd,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic [2:0] rsp_class,
  input  logic [4:0] rsp_count,
  output logic       busy,
  output logic       req_valid,
  output logic       wait_phase,
  output logic [7:0] status
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  assign busy       = (state != ST_IDLE);
  assign req_valid  = (state == ST_REQ);
  assign wait_phase = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      status <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (launch) begin
            if (is_known_cmd(cmd)) state  <= ST_REQ;
            else                   status <= {CLS_INVALID, 5'd0};
          end
        end
        ST_REQ: begin
          if (cnt == LAST) begin
            state  <= ST_IDLE;
            status <= {CLS_TIMEOUT, 5'd0};
          end else begin
            cnt <= cnt + CW'(1);
            if (req_ready) state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            state  <= ST_IDLE;
            status <= {rsp_class, rsp_count};
          end else if (cnt == LAST) begin
            state  <= ST_IDLE;
            status <= {CLS_TIMEOUT, 5'd0};
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && cnt != LAST) |=> req_valid);
  p_known_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> is_known_cmd(cmd));
  p_send_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wait_phase && rsp_valid) |=> !busy);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
  import auxeng_pkg::*;
#(
  parameter int FIFO_DEPTH     = 16,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        lnk_req_valid,
  input  logic        lnk_req_ready,
  output logic [3:0]  lnk_cmd,
  output logic [19:0] lnk_addr,
  output logic [4:0]  lnk_len,
  output logic [7:0]  lnk_wdata,
  input  logic        lnk_wpop,
  input  logic        lnk_rpush,
  input  logic [7:0]  lnk_rdata,
  input  logic        lnk_rsp_valid,
  input  logic [2:0]  lnk_rsp_class,
  input  logic [4:0]  lnk_rsp_count
);
  logic [7:0] addr_lo, addr_mid, addr_hi;
  logic [3:0] len_code;
  logic       len_none;
  logic       busy, wait_phase, soft_rst, launch, wr_open;
  logic       rd_empty, wr_empty;
  logic [7:0] rd_head, status;

  assign soft_rst = bus_wr && (bus_addr == OFS_CFG) && (bus_wdata == 8'hFF);
  assign wr_open  = bus_wr && !busy;
  assign launch   = wr_open && (bus_addr == OFS_CTRL) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo  <= '0;
      addr_mid <= '0;
      addr_hi  <= '0;
      len_code <= '0;
      len_none <= 1'b0;
    end else if (wr_open) begin
      case (bus_addr)
        OFS_A0:  addr_lo  <= bus_wdata;
        OFS_A1:  addr_mid <= bus_wdata;
        OFS_A2:  addr_hi  <= bus_wdata;
        OFS_LEN: begin
          len_code <= bus_wdata[3:0];
          len_none <= bus_wdata[7];
        end
        default: ;
      endcase
    end
  end

  assign lnk_cmd  = addr_hi[7:4];
  assign lnk_addr = {addr_hi[3:0], addr_mid, addr_lo};
  assign lnk_len  = len_none ? 5'd0 : ({1'b0, len_code} + 5'd1);

  auxeng_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk(clk), .rst(rst || soft_rst), .launch(launch), .cmd(lnk_cmd),
    .req_ready(lnk_req_ready), .rsp_valid(lnk_rsp_valid),
    .rsp_class(lnk_rsp_class), .rsp_count(lnk_rsp_count),
    .busy(busy), .req_valid(lnk_req_valid), .wait_phase(wait_phase),
    .status(status)
  );

  auxeng_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .push(wr_open && (bus_addr == OFS_WPORT)), .din(bus_wdata),
    .pop(lnk_wpop && wait_phase), .head(lnk_wdata), .empty(wr_empty)
  );

  auxeng_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .push(lnk_rpush && wait_phase), .din(lnk_rdata),
    .pop(bus_rd && (bus_addr == OFS_RPORT)), .head(rd_head), .empty(rd_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_A0:    bus_rdata <= addr_lo;
        OFS_A1:    bus_rdata <= addr_mid;
        OFS_A2:    bus_rdata <= addr_hi;
        OFS_LEN:   bus_rdata <= {len_none, 3'b000, len_code};
        OFS_RPORT: bus_rdata <= rd_head;
        OFS_CTRL:  bus_rdata <= {7'd0, busy};
        OFS_STAT:  bus_rdata <= status;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  p_lock_addr_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(addr_lo) && $stable(addr_mid) && $stable(addr_hi)
              && $stable(len_code)));
  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_RPORT && rd_empty) |=> (bus_rdata == 8'h00));
  p_wfifo_quiet_idle_r5: assert property (@(posedge clk) disable iff (rst)
    wr_empty |-> (lnk_wdata == 8'h00));
endmodule

// File: tb/aux_req_engine_test.sv
`timescale 1ns/1ps
module aux_req_engine_test;
  localparam int TMO = 40;

  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic        lnk_req_valid, lnk_req_ready = 0;
  logic [3:0]  lnk_cmd;
  logic [19:0] lnk_addr;
  logic [4:0]  lnk_len;
  logic [7:0]  lnk_wdata, lnk_rdata = 0;
  logic        lnk_wpop = 0, lnk_rpush = 0, lnk_rsp_valid = 0;
  logic [2:0]  lnk_rsp_class = 0;
  logic [4:0]  lnk_rsp_count = 0;

  int nchk = 0, nbad = 0;
  integer seed = 1234;
  logic [7:0] wbuf [20];
  logic [7:0] rbuf [20];

  aux_req_engine #(.FIFO_DEPTH(16), .TIMEOUT_CYCLES(TMO)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [4:0] exp_len(input int n);
    return (n == 0) ? 5'd0 : 5'(n);
  endfunction

  function automatic logic [7:0] len_reg(input int n);
    return (n == 0) ? 8'h80 : 8'(n - 1);
  endfunction

  // One full request; nbytes = programmed length, extra = pushes beyond it
  task automatic xact(input logic [3:0] cmd, input logic [19:0] adr, input int nbytes,
                      input int extra, input int nreply, input logic [2:0] cls,
                      input logic [4:0] cnt, input bit poke_busy);
    logic [7:0] v;
    bit is_wr;
    int nread;
    is_wr = (cmd[0] == 1'b0);
    wr(8'h76, 8'hFF);
    wr(8'h7D, adr[7:0]);
    wr(8'h7E, adr[15:8]);
    wr(8'h7F, {cmd, adr[19:16]});
    wr(8'h80, len_reg(nbytes));
    rd(8'h80, v); chk("R4 length reg", v, len_reg(nbytes));
    if (is_wr) for (int i = 0; i < nbytes + extra; i++) wr(8'h81, wbuf[i]);
    wr(8'h83, 8'h01);
    if (poke_busy) begin
      wr(8'h7D, ~adr[7:0]);
      wr(8'h81, 8'h5A);
      rd(8'h83, v); chk("R6 send bit set in flight", v, 8'h01);
    end
    chk("R3 req valid", lnk_req_valid, 1);
    chk("R3 cmd", lnk_cmd, cmd);
    chk("R3 addr", lnk_addr, adr);
    chk("R4 link len", lnk_len, exp_len(nbytes));
    @(negedge clk);
    chk("R3 req held", lnk_req_valid, 1);
    lnk_req_ready = 1;
    @(negedge clk);
    lnk_req_ready = 0;
    if (is_wr) begin
      for (int i = 0; i < nbytes; i++) begin
        chk("R5 write order", lnk_wdata, wbuf[i]);
        lnk_wpop = 1;
        @(negedge clk);
        lnk_wpop = 0;
      end
      chk("R5/R11 write fifo drained", lnk_wdata, 8'h00);
    end else begin
      for (int i = 0; i < nreply; i++) begin
        lnk_rpush = 1; lnk_rdata = rbuf[i];
        @(negedge clk);
        lnk_rpush = 0;
      end
    end
    lnk_rsp_valid = 1; lnk_rsp_class = cls; lnk_rsp_count = cnt;
    @(negedge clk);
    lnk_rsp_valid = 0;
    rd(8'h83, v); chk("R6 send bit cleared", v, 8'h00);
    rd(8'h84, v); chk("R7 status", v, {cls, cnt});
    rd(8'h7D, v); chk("R11 address kept", v, adr[7:0]);
    if (!is_wr) begin
      nread = (nreply > 16) ? 16 : nreply;
      for (int i = 0; i < nread; i++) begin
        rd(8'h82, v); chk("R8 read order", v, rbuf[i]);
      end
      rd(8'h82, v); chk("R8 empty read zero", v, 8'h00);
    end
  endtask

  initial begin
    logic [7:0] v;
    logic [3:0] cmds [4];
    int polls;
    cmds[0] = 4'h8; cmds[1] = 4'h9; cmds[2] = 4'h0; cmds[3] = 4'h1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(8'h84, v); chk("R1 status reset", v, 8'h00);
    rd(8'h83, v); chk("R1 ctrl reset", v, 8'h00);
    rd(8'h7F, v); chk("R1 addr hi reset", v, 8'h00);
    rd(8'h82, v); chk("R1/R8 rport reset", v, 8'h00);
    chk("R1 no request", lnk_req_valid, 0);

    // directed: native write 3 bytes, with busy-time pokes (R11)
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xact(4'h8, 20'hA5C3E, 3, 0, 0, 3'd3, 5'd3, 1'b1);
    // directed: I2C write overflow 18 pushes, 16 kept (R5)
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'hC0 + i);
    xact(4'h0, 20'h00050, 16, 2, 0, 3'd3, 5'd16, 1'b0);
    // directed: native read with 18 reply bytes, 16 kept (R8)
    for (int i = 0; i < 18; i++) rbuf[i] = 8'(8'h40 + 3 * i);
    xact(4'h9, 20'hFFFFF, 16, 0, 18, 3'd3, 5'd16, 1'b0);
    // directed: no-payload I2C read, reply I2C NACK (R4, R7)
    xact(4'h1, 20'h00037, 0, 0, 0, 3'd5, 5'd0, 1'b0);

    // random transactions
    for (int t = 0; t < 8; t++) begin
      logic [3:0] c;
      logic [19:0] a;
      int n;
      c = cmds[$unsigned($random(seed)) % 4];
      a = 20'($random(seed));
      n = 1 + $unsigned($random(seed)) % 16;
      for (int i = 0; i < 16; i++) begin
        wbuf[i] = 8'($random(seed));
        rbuf[i] = 8'($random(seed));
      end
      xact(c, a, n, 0, (c[0] ? n : 0), 3'(1 + $unsigned($random(seed)) % 3),
           5'(n), 1'b0);
    end

    // R9 invalid command
    wr(8'h76, 8'hFF);
    wr(8'h7F, 8'h42);
    wr(8'h83, 8'h01);
    chk("R9 no link request", lnk_req_valid, 0);
    @(negedge clk);
    chk("R9 still no link request", lnk_req_valid, 0);
    rd(8'h84, v); chk("R9 invalid status", v, 8'h80);
    rd(8'h83, v); chk("R9 send bit clear", v, 8'h00);

    // R10 timeout
    wr(8'h76, 8'hFF);
    wr(8'h7F, 8'h90);
    wr(8'h80, 8'h03);
    wr(8'h83, 8'h01);
    rd(8'h83, v); chk("R10 busy before limit", v, 8'h01);
    polls = 0;
    while (v != 8'h00 && polls < 200) begin
      rd(8'h83, v);
      polls++;
    end
    chk("R10 send bit cleared by timeout", v, 8'h00);
    chk("R10 not before limit", (polls >= TMO - 3) ? 1 : 0, 1);
    rd(8'h84, v); chk("R10 timeout status", v, 8'hE0);

    // R2 soft reset: aborts in flight, clears status and fifos
    wr(8'h80, 8'h80);
    wr(8'h7F, 8'h80);
    wr(8'h83, 8'h01);
    chk("R2 pre-reset request", lnk_req_valid, 1);
    wr(8'h76, 8'hFF);
    chk("R2 request dropped", lnk_req_valid, 0);
    rd(8'h83, v); chk("R2 ctrl cleared", v, 8'h00);
    rd(8'h84, v); chk("R2 status cleared", v, 8'h00);
    wr(8'h7F, 8'h00);
    wr(8'h81, 8'h99);
    chk("R5 pushed head", lnk_wdata, 8'h99);
    wr(8'h76, 8'hFF);
    chk("R2 write fifo flushed", lnk_wdata, 8'h00);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule